// File: doc/BRIEF.md
# Bank Byte Capture and Memory Select Decoder

This block sits between a 16-bit-address processor with a multiplexed bank byte and its memory and peripheral devices. In the low half of each bus clock (`phi2` low) the processor places the upper address byte on its data pins. The block passes that byte straight through while `phi2` is low and holds it while `phi2` is high, so that the 24-bit address stays steady for the whole data phase. In the high half the same pins carry ordinary data. The block steers that data in the correct direction between the processor side and the device side.

The 24-bit address is split two ways. Bank zero is mapped into four equal quarters: RAM, program ROM, peripheral I/O and system ROM. The decode of these quarters uses only the top address bits. Every other bank goes to a single expansion select. All selects, the read enable and the write strobe are active-low. They can be asserted only in the high phase of a cycle that the processor marks as a valid data or program access. A write-protect input stops the write strobe from reaching the two ROM quarters.

Top module: `bus_bank_decoder`

## Requirements
- R1: While `phi2` is low, `bank_addr` equals `cpu_d_in`. While `phi2` is high, `bank_addr` holds the value sampled at the last rising `clk` edge with `phi2` low. Reset clears the held value to 0x00. `full_addr` is `{bank_addr, addr}`.
- R2: With `phi2` high and `rwb`=1 and (`vda` or `vpa`), `cpu_d_oe`=1 and `cpu_d_out` equals `mem_d_in`. With `phi2` high, `rwb`=0 and `vda`=1, `mem_d_oe`=1 and `mem_d_out` equals `cpu_d_in`. In every other case both output enables are 0.
- R3: `bank_zero` is 1 exactly when all eight bits of `bank_addr` are 0.
- R4: In bank zero with an access active (`phi2` high and (`vda` or `vpa`)), address bits 15:14 select the quarter. The value 0 selects `ram_cs_n`, 1 selects `prg_cs_n`, 2 selects `io_cs_n` and 3 selects `sys_cs_n`. The boundaries are 0x3FFF/0x4000, 0x7FFF/0x8000 and 0xBFFF/0xC000.
- R5: With any nonzero bank and an access active, only `exp_cs_n` is asserted, and none of the four bank-zero selects is asserted.
- R6: While `phi2` is low, or while `vda` and `vpa` are both 0, every select, `rd_n` and `wr_n` stay high.
- R7: `rd_n` is low exactly when `phi2` is high, `rwb` is 1 and (`vda` or `vpa`) is 1.
- R8: `wr_n` is low only when `phi2` is high, `rwb` is 0, `vda` is 1 and the target is RAM, I/O or expansion. With `rom_wp`=1, a write to program ROM or system ROM leaves `wr_n` high.
- R9: With `rom_wp`=0, a write to program ROM or system ROM drives `wr_n` low under the same conditions as a RAM write.
- R10: At most one of the five chip selects is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bank byte |
| rst_n | input | 1 | Synchronous active-low reset |
| phi2 | input | 1 | Bus phase: low = address/bank phase, high = data phase |
| addr | input | 16 | Processor address bits 15:0 |
| rwb | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Valid data address |
| vpa | input | 1 | Valid program address |
| rom_wp | input | 1 | 1 = block write strobes to the ROM quarters |
| cpu_d_in | input | 8 | Processor data pins, inbound (bank byte or write data) |
| cpu_d_out | output | 8 | Read data toward the processor pins |
| cpu_d_oe | output | 1 | Drive enable for `cpu_d_out` |
| mem_d_in | input | 8 | Device-side read data |
| mem_d_out | output | 8 | Write data toward the devices |
| mem_d_oe | output | 1 | Drive enable for `mem_d_out` |
| bank_addr | output | 8 | Address bits 23:16 |
| full_addr | output | 24 | Complete 24-bit address |
| bank_zero | output | 1 | High when the bank is 0x00 |
| ram_cs_n | output | 1 | Bank-zero RAM select |
| prg_cs_n | output | 1 | Bank-zero program ROM select |
| io_cs_n | output | 1 | Bank-zero I/O select |
| sys_cs_n | output | 1 | Bank-zero system ROM select |
| exp_cs_n | output | 1 | Expansion-bank select |
| rd_n | output | 1 | Read output enable |
| wr_n | output | 1 | Write strobe |

## Verification
The only register in the block is the held bank byte, and it is loaded on a rising `clk` edge while `phi2` is low. Every other output follows the present inputs with no clock delay. Each bench cycle therefore drives the bank phase at one falling edge and lets one rising edge capture the byte. It then raises `phi2` with the address and control lines at the next falling edge and samples 1 ns later, well before the following rising edge. The transparent-phase checks sample 1 ns after the data pins change with `phi2` low and no edge in between, and the hold check changes `cpu_d_in` while `phi2` is high to show that the latched value does not move.

// File: rtl/bankdec_pkg.sv
// Package: shared types for the bank capture and select decoder.
// Assumes one select per region, with the bit order used by every submodule.
package bankdec_pkg;

    // Region select vector; one bit per device group, active-high inside the block
    typedef struct packed {
        logic exp;
        logic sys;
        logic io;
        logic prg;
        logic ram;
    } sel_t;

    localparam int NUM_SEL = 5;

    // Quarter codes of bank zero, taken from the top two address bits
    typedef enum logic [1:0] {
        Q_RAM = 2'd0,
        Q_PRG = 2'd1,
        Q_IO  = 2'd2,
        Q_SYS = 2'd3
    } quarter_e;

    // True for regions that hold read-only memory
    function automatic logic is_rom(input sel_t s);
        return s.prg | s.sys;
    endfunction

endpackage

// File: rtl/bank_capture.sv
// Module: bank_capture
// Emulates a transparent latch on the multiplexed bank byte. The byte passes
// through while phi2 is low and is held, as sampled on clk, while phi2 is high.
// Assumes phi2 is synchronous to clk and stays low for at least one clk edge.
module bank_capture #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic [BANK_W-1:0] d_in,
    output logic [BANK_W-1:0] bank,
    output logic              zero
);

    logic [BANK_W-1:0] hold_q;

    // Sample the bank byte on every edge of the address phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (!phi2) begin
            hold_q <= d_in;
        end
    end

    // Transparent while low, held while high
    always_comb begin
        bank = phi2 ? hold_q : d_in;
    end

    // One wide NOR across the bank byte
    always_comb begin
        zero = ~|bank;
    end

endmodule

// File: rtl/region_decode.sv
// Module: region_decode
// Maps the address onto one region. Bank zero is split into 2**DEC_BITS equal
// parts from the top address bits, and any other bank maps to expansion.
// Assumes DEC_BITS is 2, so that the four bank-zero regions are filled.
module region_decode
    import bankdec_pkg::*;
#(
    parameter int DEC_BITS = 2
) (
    input  logic                bank_zero,
    input  logic [DEC_BITS-1:0] top_bits,
    output sel_t                hit
);

    localparam int NQ = 1 << DEC_BITS;

    logic [NQ-1:0] quarter_hit;

    // One comparator per bank-zero part
    for (genvar q = 0; q < NQ; q++) begin : g_quarter
        always_comb begin
            quarter_hit[q] = bank_zero && (top_bits == DEC_BITS'(q));
        end
    end

    // Assemble the region vector
    always_comb begin
        hit     = '0;
        hit.ram = quarter_hit[Q_RAM];
        hit.prg = quarter_hit[Q_PRG];
        hit.io  = quarter_hit[Q_IO];
        hit.sys = quarter_hit[Q_SYS];
        hit.exp = ~bank_zero;
    end

endmodule

// File: rtl/strobe_gen.sv
// Module: strobe_gen
// Qualifies region hits into active-low selects, a read enable and a write strobe.
// Assumes hit is one-hot. All outputs stay inactive in the address phase.
module strobe_gen
    import bankdec_pkg::*;
(
    input  logic phi2,
    input  logic rwb,
    input  logic vda,
    input  logic vpa,
    input  logic rom_wp,
    input  sel_t hit,
    output sel_t cs_n,
    output logic rd_n,
    output logic wr_n
);

    logic access_ok;
    logic wr_target_ok;

    // An access is live only in the data phase of a marked-valid cycle
    always_comb begin
        access_ok = phi2 && (vda || vpa);
    end

    // Chip selects follow the hit vector during a live access
    always_comb begin
        cs_n = access_ok ? ~hit : '1;
    end

    // Read enable for any valid read
    always_comb begin
        rd_n = ~(access_ok && rwb);
    end

    // Write strobe: data address only, ROM blocked when protected
    always_comb begin
        wr_target_ok = ~(rom_wp && is_rom(hit));
        wr_n = ~(phi2 && !rwb && vda && wr_target_ok);
    end

endmodule

// File: rtl/data_steer.sv
// Module: data_steer
// Directional buffer between the processor pins and the device data bus.
// Assumes the bank byte phase (phi2 low) must never drive either side.
module data_steer #(
    parameter int DATA_W = 8
) (
    input  logic              phi2,
    input  logic              rwb,
    input  logic              vda,
    input  logic              vpa,
    input  logic [DATA_W-1:0] cpu_in,
    input  logic [DATA_W-1:0] mem_in,
    output logic [DATA_W-1:0] cpu_out,
    output logic              cpu_oe,
    output logic [DATA_W-1:0] mem_out,
    output logic              mem_oe
);

    // Read direction: device data toward the processor
    always_comb begin
        cpu_oe  = phi2 && rwb && (vda || vpa);
        cpu_out = mem_in;
    end

    // Write direction: processor data toward the devices
    always_comb begin
        mem_oe  = phi2 && !rwb && vda;
        mem_out = cpu_in;
    end

endmodule

// File: rtl/bus_bank_decoder.sv
// Module: bus_bank_decoder (top)
// Recovers the bank byte from the multiplexed data pins, forms the 24-bit
// address, decodes the device selects and steers the data bus.
// Assumes phi2, addr and the control lines are synchronous to clk.
module bus_bank_decoder
    import bankdec_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BANK_W   = 8,
    parameter int DATA_W   = 8,
    parameter int DEC_BITS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     phi2,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     rwb,
    input  logic                     vda,
    input  logic                     vpa,
    input  logic                     rom_wp,
    input  logic [DATA_W-1:0]        cpu_d_in,
    output logic [DATA_W-1:0]        cpu_d_out,
    output logic                     cpu_d_oe,
    input  logic [DATA_W-1:0]        mem_d_in,
    output logic [DATA_W-1:0]        mem_d_out,
    output logic                     mem_d_oe,
    output logic [BANK_W-1:0]        bank_addr,
    output logic [BANK_W+ADDR_W-1:0] full_addr,
    output logic                     bank_zero,
    output logic                     ram_cs_n,
    output logic                     prg_cs_n,
    output logic                     io_cs_n,
    output logic                     sys_cs_n,
    output logic                     exp_cs_n,
    output logic                     rd_n,
    output logic                     wr_n
);

    localparam int FULL_W = BANK_W + ADDR_W;

    sel_t hit;
    sel_t cs_vec_n;

    bank_capture #(.BANK_W(BANK_W)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .phi2 (phi2),
        .d_in (cpu_d_in[BANK_W-1:0]),
        .bank (bank_addr),
        .zero (bank_zero)
    );

    region_decode #(.DEC_BITS(DEC_BITS)) u_dec (
        .bank_zero(bank_zero),
        .top_bits (addr[ADDR_W-1 -: DEC_BITS]),
        .hit      (hit)
    );

    strobe_gen u_strb (
        .phi2  (phi2),
        .rwb   (rwb),
        .vda   (vda),
        .vpa   (vpa),
        .rom_wp(rom_wp),
        .hit   (hit),
        .cs_n  (cs_vec_n),
        .rd_n  (rd_n),
        .wr_n  (wr_n)
    );

    data_steer #(.DATA_W(DATA_W)) u_data (
        .phi2   (phi2),
        .rwb    (rwb),
        .vda    (vda),
        .vpa    (vpa),
        .cpu_in (cpu_d_in),
        .mem_in (mem_d_in),
        .cpu_out(cpu_d_out),
        .cpu_oe (cpu_d_oe),
        .mem_out(mem_d_out),
        .mem_oe (mem_d_oe)
    );

    // Concatenate bank and offset into the flat address
    always_comb begin
        full_addr = FULL_W'({bank_addr, addr});
    end

    // Fan the select vector out to named pins
    always_comb begin
        ram_cs_n = cs_vec_n.ram;
        prg_cs_n = cs_vec_n.prg;
        io_cs_n  = cs_vec_n.io;
        sys_cs_n = cs_vec_n.sys;
        exp_cs_n = cs_vec_n.exp;
    end

endmodule

// File: rtl/bus_bank_decoder_chk.sv
// Module: bus_bank_decoder_chk
// Property checker bound to the top module. It watches only the port-level behaviour.
module bus_bank_decoder_chk #(
    parameter int BANK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phi2,
    input logic              rwb,
    input logic              vda,
    input logic              vpa,
    input logic              rom_wp,
    input logic [BANK_W-1:0] bank_addr,
    input logic              bank_zero,
    input logic              ram_cs_n,
    input logic              prg_cs_n,
    input logic              io_cs_n,
    input logic              sys_cs_n,
    input logic              exp_cs_n,
    input logic              rd_n,
    input logic              wr_n
);

    logic [4:0] cs_act;
    assign cs_act = ~{exp_cs_n, sys_cs_n, io_cs_n, prg_cs_n, ram_cs_n};

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_act)); // R10

    AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!phi2 || (!vda && !vpa)) |-> (cs_act == 5'b0 && rd_n && wr_n)); // R6

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && $past(phi2)) |-> $stable(bank_addr)); // R1

    AST_NONZERO_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_zero |-> (ram_cs_n && prg_cs_n && io_cs_n && sys_cs_n)); // R5

    AST_WR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (phi2 && !rwb && vda)); // R8

    AST_WP_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_wp && (!prg_cs_n || !sys_cs_n)) |-> wr_n); // R8

    AST_RD_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (phi2 && rwb && (vda || vpa))); // R7

endmodule

bind bus_bank_decoder bus_bank_decoder_chk #(.BANK_W(BANK_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phi2     (phi2),
    .rwb      (rwb),
    .vda      (vda),
    .vpa      (vpa),
    .rom_wp   (rom_wp),
    .bank_addr(bank_addr),
    .bank_zero(bank_zero),
    .ram_cs_n (ram_cs_n),
    .prg_cs_n (prg_cs_n),
    .io_cs_n  (io_cs_n),
    .sys_cs_n (sys_cs_n),
    .exp_cs_n (exp_cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n)
);

// File: tb/bus_bank_decoder_tb.sv
// Directed bench for bus_bank_decoder: one task per scenario.
module bus_bank_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        phi2;
    logic [15:0] addr;
    logic        rwb, vda, vpa, rom_wp;
    logic [7:0]  cpu_d_in, mem_d_in;
    logic [7:0]  cpu_d_out, mem_d_out;
    logic        cpu_d_oe, mem_d_oe;
    logic [7:0]  bank_addr;
    logic [23:0] full_addr;
    logic        bank_zero;
    logic        ram_cs_n, prg_cs_n, io_cs_n, sys_cs_n, exp_cs_n, rd_n, wr_n;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    bus_bank_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .addr(addr), .rwb(rwb),
        .vda(vda), .vpa(vpa), .rom_wp(rom_wp), .cpu_d_in(cpu_d_in),
        .cpu_d_out(cpu_d_out), .cpu_d_oe(cpu_d_oe), .mem_d_in(mem_d_in),
        .mem_d_out(mem_d_out), .mem_d_oe(mem_d_oe), .bank_addr(bank_addr),
        .full_addr(full_addr), .bank_zero(bank_zero), .ram_cs_n(ram_cs_n),
        .prg_cs_n(prg_cs_n), .io_cs_n(io_cs_n), .sys_cs_n(sys_cs_n),
        .exp_cs_n(exp_cs_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] act_sel();
        return ~{exp_cs_n, sys_cs_n, io_cs_n, prg_cs_n, ram_cs_n};
    endfunction

    // Drive one bus cycle: bank phase, one capture edge, then the data phase
    task automatic bus_cycle(input logic [7:0] bank, input logic [15:0] a,
                             input logic rw, input logic d_v, input logic p_v,
                             input logic [7:0] wdat, input logic [7:0] rdat);
        @(negedge clk);
        phi2 = 1'b0; cpu_d_in = bank; addr = a; rwb = rw; vda = d_v; vpa = p_v;
        @(negedge clk);
        phi2 = 1'b1; cpu_d_in = wdat; mem_d_in = rdat;
        #1;
    endtask

    // Expected outputs in the data phase, computed from R3..R9
    task automatic check_cycle(input string tag, input logic [7:0] bank,
                               input logic [15:0] a);
        logic [4:0] region;
        logic       live;
        logic       wr_exp;
        region = (bank != 8'h00) ? 5'b10000 : (5'b00001 << a[15:14]);
        live   = vda || vpa;
        wr_exp = !rwb && vda && !(rom_wp && (region[1] || region[3]));
        check(tag, "selects R4/R5",  {27'b0, act_sel()}, {27'b0, live ? region : 5'b0});
        check(tag, "bank_zero R3",   {31'b0, bank_zero}, {31'b0, bank == 8'h00});
        check(tag, "full_addr R1",   {8'b0, full_addr},  {8'b0, bank, a});
        check(tag, "rd_n R7",        {31'b0, rd_n},      {31'b0, !(rwb && live)});
        check(tag, "wr_n R8/R9",     {31'b0, wr_n},      {31'b0, !wr_exp});
        check(tag, "one select R10", {31'b0, $countones(act_sel()) <= 1}, 32'd1);
    endtask

    task automatic t_reset();
        phi2 = 1'b1; vda = 1'b0; vpa = 1'b0; rwb = 1'b1; rom_wp = 1'b1;
        addr = 16'h0000; cpu_d_in = 8'hA5; mem_d_in = 8'h00; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1", "reset bank", {24'b0, bank_addr}, 32'h0);
        check("R3", "reset bank_zero", {31'b0, bank_zero}, 32'd1);
        check("R6", "reset selects", {27'b0, act_sel()}, 32'h0);
        check("R6", "reset rd/wr", {30'b0, rd_n, wr_n}, 32'h3);
    endtask

    task automatic t_transparent();
        @(negedge clk); phi2 = 1'b0; vda = 1'b1; rwb = 1'b0; cpu_d_in = 8'h5A; #1;
        check("R1", "pass low 5A", {24'b0, bank_addr}, 32'h5A);
        check("R6", "no select in low phase", {27'b0, act_sel()}, 32'h0);
        check("R6", "no strobe in low phase", {30'b0, rd_n, wr_n}, 32'h3);
        check("R2", "no drive in low phase", {30'b0, cpu_d_oe, mem_d_oe}, 32'h0);
        cpu_d_in = 8'h33; #1;
        check("R1", "pass low 33", {24'b0, bank_addr}, 32'h33);
        @(negedge clk); phi2 = 1'b1; cpu_d_in = 8'h77; #1;
        check("R1", "hold high", {24'b0, bank_addr}, 32'h33);
        @(negedge clk); cpu_d_in = 8'h00; #1;
        check("R1", "hold after edge", {24'b0, bank_addr}, 32'h33);
    endtask

    task automatic t_bank0_map();
        logic [15:0] pts [8] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h7FFF,
                                 16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF};
        rom_wp = 1'b1;
        for (int i = 0; i < 8; i++) begin
            bus_cycle(8'h00, pts[i], 1'b1, 1'b0, 1'b1, 8'h00, 8'h11);
            check_cycle("R4 boundary", 8'h00, pts[i]);
        end
    endtask

    task automatic t_other_banks();
        logic [7:0]  bk [3] = '{8'h01, 8'hFF, 8'h80};
        logic [15:0] ad [3] = '{16'h0000, 16'hFFFF, 16'h4000};
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 3; j++) begin
                bus_cycle(bk[i], ad[j], 1'b1, 1'b1, 1'b0, 8'h00, 8'h22);
                check_cycle("R5 expansion", bk[i], ad[j]);
            end
        end
    endtask

    task automatic t_invalid();
        bus_cycle(8'h00, 16'h1234, 1'b1, 1'b0, 1'b0, 8'h00, 8'h33);
        check_cycle("R6 read idle", 8'h00, 16'h1234);
        check("R2", "idle no cpu drive", {31'b0, cpu_d_oe}, 32'h0);
        bus_cycle(8'h01, 16'h8000, 1'b0, 1'b0, 1'b0, 8'h44, 8'h00);
        check_cycle("R6 write idle", 8'h01, 16'h8000);
        check("R2", "idle no mem drive", {31'b0, mem_d_oe}, 32'h0);
    endtask

    task automatic t_writes();
        logic [15:0] pts [4] = '{16'h3FFF, 16'h4000, 16'h8000, 16'hC000};
        rom_wp = 1'b1;
        for (int i = 0; i < 4; i++) begin
            bus_cycle(8'h00, pts[i], 1'b0, 1'b1, 1'b0, 8'h5C, 8'h00);
            check_cycle("R8 protected", 8'h00, pts[i]);
        end
        bus_cycle(8'h02, 16'h7000, 1'b0, 1'b1, 1'b0, 8'h5C, 8'h00);
        check_cycle("R8 expansion write", 8'h02, 16'h7000);
        bus_cycle(8'h00, 16'h0100, 1'b0, 1'b0, 1'b1, 8'h5C, 8'h00);
        check_cycle("R8 program-only write", 8'h00, 16'h0100);
        rom_wp = 1'b0;
        for (int i = 0; i < 4; i++) begin
            bus_cycle(8'h00, pts[i], 1'b0, 1'b1, 1'b0, 8'h5C, 8'h00);
            check_cycle("R9 unprotected", 8'h00, pts[i]);
        end
        rom_wp = 1'b1;
    endtask

    task automatic t_data();
        bus_cycle(8'h00, 16'h0010, 1'b1, 1'b1, 1'b0, 8'h00, 8'hC3);
        check("R2", "read oe", {30'b0, cpu_d_oe, mem_d_oe}, 32'h2);
        check("R2", "read data", {24'b0, cpu_d_out}, 32'hC3);
        bus_cycle(8'h00, 16'h0010, 1'b0, 1'b1, 1'b0, 8'h3C, 8'h00);
        check("R2", "write oe", {30'b0, cpu_d_oe, mem_d_oe}, 32'h1);
        check("R2", "write data", {24'b0, mem_d_out}, 32'h3C);
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_bank0_map();
        t_other_banks();
        t_invalid();
        t_writes();
        t_data();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule